// File: doc/BRIEF.md
# Split transaction microframe scheduler

This block decides, for a single periodic split-transaction descriptor, whether that descriptor runs in the current microframe and which kind of split it runs. The low three bits of the free-running frame index pick one bit from each of two 8-bit masks: a start mask and a complete mask. The descriptor's active bit and split-state bit decide which mask applies. Each new frame index value is evaluated once. An eligible evaluation produces a single-cycle execute pulse. Alongside the pulse the block presents the split kind, the IN/OUT token and the data buffer address. The address is built from the selected page pointer and the current offset.

When a split transaction finishes with interrupt-on-complete set, the interrupt request is held pending. It is released on the first evaluated frame index that lands on a multiple of a programmable threshold of 1, 2, 4 or 8 microframes. A mask that would be consulted while it is all zero is reported as an error, and no execution takes place. Descriptor fetch, the bus protocol engine and the walk of the periodic list sit outside this block. All descriptor fields arrive on plain ports.

Top module: `split_uframe_sched`

## Requirements
- R1: With active_i=1 and split_state_i=0 (start pending), an evaluation whose start-mask bit smask_i[frindex_i[2:0]] is 1 raises exec_o and sets split_kind_o=0. If that bit is 0, exec_o stays 0.
- R2: With active_i=1 and split_state_i=1 (complete pending), eligibility follows only cmask_i[frindex_i[2:0]], and split_kind_o=1 on execution. The start mask has no effect in this state, and the complete mask has no effect when split_state_i=0.
- R3: The block evaluates a microframe on the first clock after reset and on every clock where frindex_i differs from the value it held on the previous clock. exec_o is high for exactly one clock, the clock after that evaluation. It stays low while frindex_i is held.
- R4: With active_i=0, exec_o and mask_err_o stay 0 whatever the masks hold.
- R5: With active_i=1, if the mask selected by split_state_i is all zero, the evaluation sets mask_err_o=1 and exec_o stays 0. mask_err_o keeps the result of the latest evaluation.
- R6: At each evaluation, token_in_o takes dir_i, where 0 means OUT and 1 means IN.
- R7: At each evaluation, buf_addr_o takes {page1_i, offset_i} when page_sel_i=1 and {page0_i, offset_i} when page_sel_i=0. The page pointer forms bits 31:12 and the offset forms bits 11:0.
- R8: A clock with split_done_i=1 and ioc_i=1 makes an interrupt pending. irq_o pulses for one clock, aligned with exec_o timing, on the first later evaluation whose frindex_i is a multiple of 2^thresh_sel_i microframes (thresh_sel_i 0,1,2,3 give 1,2,4,8). The pending state is then cleared.
- R9: split_done_i with ioc_i=0 never makes an interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frindex_i | input | 14 | Frame index counter; bits 2:0 give the microframe |
| smask_i | input | 8 | Start-split microframe mask |
| cmask_i | input | 8 | Complete-split microframe mask |
| active_i | input | 1 | Descriptor active |
| split_state_i | input | 1 | 0 start pending, 1 complete pending |
| dir_i | input | 1 | 0 OUT, 1 IN |
| page_sel_i | input | 1 | Page pointer select |
| offset_i | input | 12 | Current offset within page |
| page0_i | input | 20 | Page pointer 0, address bits 31:12 |
| page1_i | input | 20 | Page pointer 1, address bits 31:12 |
| ioc_i | input | 1 | Interrupt on complete |
| split_done_i | input | 1 | Split transaction finished strobe |
| thresh_sel_i | input | 2 | Interrupt threshold, 2^n microframes |
| exec_o | output | 1 | One-clock execute pulse |
| split_kind_o | output | 1 | 0 start-split, 1 complete-split |
| token_in_o | output | 1 | 1 IN token, 0 OUT token |
| buf_addr_o | output | 32 | Data buffer address |
| mask_err_o | output | 1 | Applicable mask was all zero |
| irq_o | output | 1 | Deferred interrupt pulse |

## Verification
A wrong stored frame index shows at the ports as a missing execute pulse or an extra one. This becomes visible one clock after the index changes, or one clock after it is held. A stale or lost pending-interrupt bit stays hidden until the next threshold boundary. At that point irq_o either fails to pulse or pulses once too often, so a fault can take up to eight microframes to appear. A wrong mask choice shows up on the very next evaluation as a wrong execute decision, a wrong split_kind_o value, or a wrong mask_err_o value.

// File: rtl/split_sched_pkg.sv
package split_sched_pkg;
  localparam int unsigned MASK_W  = 8;
  localparam int unsigned UF_W    = $clog2(MASK_W);
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned PAGE_W  = ADDR_W - OFS_W;
  localparam int unsigned THR_W   = 2;

  typedef enum logic {
    SPLIT_START    = 1'b0,
    SPLIT_COMPLETE = 1'b1
  } split_kind_e;
endpackage

// File: rtl/uframe_mask_sel.sv
module uframe_mask_sel #(
  parameter int unsigned MASK_W = 8,
  localparam int unsigned UF_W = $clog2(MASK_W)
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic [UF_W-1:0]   uf_i,
  output logic              hit_o,
  output logic              zero_o
);
  logic [MASK_W-1:0] onehot;

  for (genvar g = 0; g < MASK_W; g++) begin : g_dec
    assign onehot[g] = (uf_i == UF_W'(g)) & mask_i[g];
  end

  assign hit_o  = |onehot;
  assign zero_o = ~|mask_i;
endmodule

// File: rtl/split_eligibility.sv
module split_eligibility
  import split_sched_pkg::*;
(
  input  logic        active_i,
  input  logic        split_state_i,
  input  logic        s_hit_i,
  input  logic        s_zero_i,
  input  logic        c_hit_i,
  input  logic        c_zero_i,
  output logic        run_o,
  output split_kind_e kind_o,
  output logic        err_o
);
  logic hit, zero;

  always_comb begin
    kind_o = split_state_i ? SPLIT_COMPLETE : SPLIT_START;
    hit    = split_state_i ? c_hit_i  : s_hit_i;
    zero   = split_state_i ? c_zero_i : s_zero_i;
    err_o  = active_i & zero;
    run_o  = active_i & ~zero & hit;
  end
endmodule

// File: rtl/buf_addr_gen.sv
module buf_addr_gen #(
  parameter int unsigned PAGE_W = 20,
  parameter int unsigned OFS_W  = 12,
  localparam int unsigned ADDR_W = PAGE_W + OFS_W
) (
  input  logic              page_sel_i,
  input  logic [PAGE_W-1:0] page0_i,
  input  logic [PAGE_W-1:0] page1_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = {(page_sel_i ? page1_i : page0_i), offset_i};
endmodule

// File: rtl/irq_defer.sv
module irq_defer #(
  parameter int unsigned FIDX_W = 14,
  parameter int unsigned THR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [FIDX_W-1:0] frindex_i,
  input  logic [THR_W-1:0]  thresh_sel_i,
  input  logic              ioc_i,
  input  logic              split_done_i,
  output logic              irq_o
);
  localparam int unsigned SPAN_W = (1 << THR_W) - 1;

  logic              pend_q, irq_q;
  logic [SPAN_W-1:0] span_mask;
  logic              boundary, release_w, set_w;

  assign span_mask = SPAN_W'((1 << thresh_sel_i) - 1);
  assign boundary  = ((frindex_i[SPAN_W-1:0] & span_mask) == '0);
  assign release_w = eval_i & boundary & pend_q;
  assign set_w     = split_done_i & ioc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~release_w) | set_w;
      irq_q  <= release_w;
    end
  end

  assign irq_o = irq_q;

  // R8
  irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pend_q));

  // R9
  no_ioc_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !(split_done_i && ioc_i)) |=> !pend_q);
endmodule

// File: rtl/split_uframe_sched.sv
module split_uframe_sched
  import split_sched_pkg::*;
#(
  parameter int unsigned FIDX_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FIDX_W-1:0] frindex_i,
  input  logic [MASK_W-1:0] smask_i,
  input  logic [MASK_W-1:0] cmask_i,
  input  logic              active_i,
  input  logic              split_state_i,
  input  logic              dir_i,
  input  logic              page_sel_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [PAGE_W-1:0] page0_i,
  input  logic [PAGE_W-1:0] page1_i,
  input  logic              ioc_i,
  input  logic              split_done_i,
  input  logic [THR_W-1:0]  thresh_sel_i,
  output logic              exec_o,
  output logic              split_kind_o,
  output logic              token_in_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              mask_err_o,
  output logic              irq_o
);
  logic [FIDX_W-1:0] fidx_q;
  logic              seen_q;
  logic              eval;

  logic [1:0] hit, zero;
  logic [MASK_W-1:0] masks [2];

  assign masks[0] = smask_i;
  assign masks[1] = cmask_i;

  for (genvar m = 0; m < 2; m++) begin : g_mask
    uframe_mask_sel #(.MASK_W(MASK_W)) u_sel (
      .mask_i (masks[m]),
      .uf_i   (frindex_i[UF_W-1:0]),
      .hit_o  (hit[m]),
      .zero_o (zero[m])
    );
  end

  logic        run, err;
  split_kind_e kind;

  split_eligibility u_elig (
    .active_i      (active_i),
    .split_state_i (split_state_i),
    .s_hit_i       (hit[0]),
    .s_zero_i      (zero[0]),
    .c_hit_i       (hit[1]),
    .c_zero_i      (zero[1]),
    .run_o         (run),
    .kind_o        (kind),
    .err_o         (err)
  );

  logic [ADDR_W-1:0] addr;

  buf_addr_gen #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_addr (
    .page_sel_i (page_sel_i),
    .page0_i    (page0_i),
    .page1_i    (page1_i),
    .offset_i   (offset_i),
    .addr_o     (addr)
  );

  irq_defer #(.FIDX_W(FIDX_W), .THR_W(THR_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .eval_i       (eval),
    .frindex_i    (frindex_i),
    .thresh_sel_i (thresh_sel_i),
    .ioc_i        (ioc_i),
    .split_done_i (split_done_i),
    .irq_o        (irq_o)
  );

  // first sample after reset counts as a change
  assign eval = ~seen_q | (frindex_i != fidx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fidx_q       <= '0;
      seen_q       <= 1'b0;
      exec_o       <= 1'b0;
      split_kind_o <= 1'b0;
      token_in_o   <= 1'b0;
      buf_addr_o   <= '0;
      mask_err_o   <= 1'b0;
    end else begin
      fidx_q <= frindex_i;
      seen_q <= 1'b1;
      exec_o <= eval & run;
      if (eval) begin
        split_kind_o <= kind;
        token_in_o   <= dir_i;
        buf_addr_o   <= addr;
        mask_err_o   <= err;
      end
    end
  end

  // R4
  inactive_no_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> $past(active_i));

  // R5
  err_blocks_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_err_o |-> !exec_o);

  // R2
  kind_follows_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> (split_kind_o == $past(split_state_i)));

  // R6
  token_follows_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> (token_in_o == $past(dir_i)));

  // R3
  held_index_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $stable(frindex_i) && $past(seen_q)) |=> !exec_o);
endmodule

// File: tb/split_uframe_sched_test.sv
`timescale 1ns/1ps
module split_uframe_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] frindex = '0;
  logic [7:0]  smask = '0, cmask = '0;
  logic        active = 0, sstate = 0, dir = 0, psel = 0, ioc = 0, done = 0;
  logic [11:0] offset = '0;
  logic [19:0] page0 = '0, page1 = '0;
  logic [1:0]  thr = '0;
  logic        exec, kind, tok, merr, irq;
  logic [31:0] addr;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  split_uframe_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .frindex_i(frindex), .smask_i(smask),
    .cmask_i(cmask), .active_i(active), .split_state_i(sstate), .dir_i(dir),
    .page_sel_i(psel), .offset_i(offset), .page0_i(page0), .page1_i(page1),
    .ioc_i(ioc), .split_done_i(done), .thresh_sel_i(thr),
    .exec_o(exec), .split_kind_o(kind), .token_in_o(tok),
    .buf_addr_o(addr), .mask_err_o(merr), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive new index at negedge; outputs visible at the next negedge
  task automatic step(input logic [13:0] v);
    frindex = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R3 reset exec", {31'd0, exec}, 0);
    check("R8 reset irq", {31'd0, irq}, 0);
    check("R5 reset err", {31'd0, merr}, 0);
    check("R7 reset addr", addr, 0);
  endtask

  task automatic t_start;
    active = 1; sstate = 0; smask = 8'b0000_0100; cmask = 8'hff;
    step(14'd2);
    check("R1 start exec", {31'd0, exec}, 1);
    check("R1 start kind", {31'd0, kind}, 0);
    step(14'd3);
    check("R1 start miss", {31'd0, exec}, 0);
    step(14'd10);
    check("R1 start idx wrap", {31'd0, exec}, 1);
  endtask

  task automatic t_complete;
    sstate = 1; smask = 8'hff; cmask = 8'b1000_0000;
    step(14'd15);
    check("R2 complete exec", {31'd0, exec}, 1);
    check("R2 complete kind", {31'd0, kind}, 1);
    step(14'd14);
    check("R2 smask ignored", {31'd0, exec}, 0);
    sstate = 0; smask = 8'b0000_0001; cmask = 8'hff;
    step(14'd13);
    check("R2 cmask ignored", {31'd0, exec}, 0);
  endtask

  task automatic t_pulse;
    smask = 8'hff;
    step(14'd20);
    check("R3 pulse high", {31'd0, exec}, 1);
    @(negedge clk);
    check("R3 pulse one clock", {31'd0, exec}, 0);
    @(negedge clk);
    @(negedge clk);
    check("R3 held index quiet", {31'd0, exec}, 0);
  endtask

  task automatic t_inactive;
    active = 0; smask = 8'hff; cmask = 8'hff;
    step(14'd21);
    check("R4 inactive exec", {31'd0, exec}, 0);
    check("R4 inactive err", {31'd0, merr}, 0);
    smask = 8'h00;
    step(14'd22);
    check("R4 inactive zero mask err", {31'd0, merr}, 0);
  endtask

  task automatic t_zero;
    active = 1; sstate = 0; smask = 8'h00; cmask = 8'hff;
    step(14'd23);
    check("R5 zero err", {31'd0, merr}, 1);
    check("R5 zero no exec", {31'd0, exec}, 0);
    sstate = 1; smask = 8'hff; cmask = 8'h00;
    step(14'd24);
    check("R5 zero cmask err", {31'd0, merr}, 1);
    smask = 8'hff; cmask = 8'hff;
    step(14'd25);
    check("R5 err clears", {31'd0, merr}, 0);
    check("R5 exec resumes", {31'd0, exec}, 1);
  endtask

  task automatic t_dir;
    sstate = 0; dir = 1;
    step(14'd26);
    check("R6 IN token", {31'd0, tok}, 1);
    dir = 0;
    step(14'd27);
    check("R6 OUT token", {31'd0, tok}, 0);
  endtask

  task automatic t_addr;
    page0 = 20'hA1B2C; page1 = 20'h3D4E5; offset = 12'h7F6; psel = 0;
    step(14'd28);
    check("R7 page0 addr", addr, 32'hA1B2C7F6);
    psel = 1; offset = 12'h001;
    step(14'd29);
    check("R7 page1 addr", addr, 32'h3D4E5001);
  endtask

  task automatic t_irq;
    thr = 2'd2;
    step(14'd33);
    ioc = 1; done = 1;
    @(negedge clk);
    done = 0;
    step(14'd34);
    check("R8 not yet 34", {31'd0, irq}, 0);
    step(14'd35);
    check("R8 not yet 35", {31'd0, irq}, 0);
    step(14'd36);
    check("R8 release at 36", {31'd0, irq}, 1);
    @(negedge clk);
    check("R8 irq one clock", {31'd0, irq}, 0);
    step(14'd40);
    check("R8 pending cleared", {31'd0, irq}, 0);
    thr = 2'd3;
    done = 1;
    @(negedge clk);
    done = 0;
    step(14'd44);
    check("R8 thr8 not at 44", {31'd0, irq}, 0);
    step(14'd48);
    check("R8 thr8 at 48", {31'd0, irq}, 1);
    thr = 2'd0;
    done = 1;
    @(negedge clk);
    done = 0;
    step(14'd49);
    check("R8 thr1 next uframe", {31'd0, irq}, 1);
  endtask

  task automatic t_no_ioc;
    ioc = 0; thr = 2'd0;
    done = 1;
    @(negedge clk);
    done = 0;
    step(14'd50);
    check("R9 no ioc no irq", {31'd0, irq}, 0);
    step(14'd51);
    check("R9 no ioc later", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    t_start();
    t_complete();
    t_pulse();
    t_inactive();
    t_zero();
    t_dir();
    t_addr();
    t_irq();
    t_no_ioc();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule